// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a free-running precision time protocol clock. The clock is held as 96 bits: seconds, nanoseconds and a binary fraction of a nanosecond. On every clock cycle the time moves forward by a programmable period. The period is a whole number of nanoseconds plus a 16-bit fraction, and it is usually set to the clock period of the block. A carry out of the fraction and the rollover of the nanoseconds at one billion are both resolved in that same cycle.

A load strobe writes a complete time value, for example one set by a servo or by software through some other path. A capture strobe records the time into three registered views that always agree with each other: the full 96-bit form, a 64-bit form with seconds and nanoseconds, and a 64-bit correction-field form. The correction-field form gives the total nanoseconds plus the fraction and has no seconds field. Timestamping logic raises the capture strobe when a packet event occurs and then reads the held views.

Top module: `ptp_tod_counter`

## Requirements
- R1: While rst_ni is low, time_o, cap_v2_o, cap_v1_o and cap_cf_o all read zero.
- R2: When load_i is low, each rising clock edge adds period_frac_i to time_o[15:0]. Any carry out of bit 15 goes into the nanoseconds. The same edge adds period_ns_i to time_o[47:16]. period_ns_i must be below 1,000,000,000.
- R3: The nanosecond field time_o[47:16] never reaches 1,000,000,000. When the sum reaches that value or more, one billion is subtracted and the seconds time_o[95:48] go up by exactly one. Without a load, the seconds either stay the same or go up by one per cycle.
- R4: When load_i is high at an edge, time_o takes load_time_i after that edge and the period is not added. The layout is seconds in [95:48], nanoseconds in [47:16] and fraction in [15:0].
- R5: A loaded nanosecond value of 1,000,000,000 or more is stored as 999,999,999. The loaded seconds and fraction are kept unchanged.
- R6: When capture_i is high at an edge, cap_v2_o takes the value time_o had before that edge. This also holds when load_i is high in the same cycle.
- R7: cap_v1_o[63:32] holds the low 32 bits of the captured seconds and cap_v1_o[31:0] holds the captured nanoseconds. The fraction is dropped.
- R8: cap_cf_o[63:16] holds (seconds × 1,000,000,000 + nanoseconds) of the captured time modulo 2^48. cap_cf_o[15:0] holds the captured fraction.
- R9: When capture_i is low, all three captured views keep their values.
- R10: The seconds field wraps from 2^48−1 to 0 when the nanoseconds roll over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Overwrite the time with load_time_i |
| load_time_i | input | 96 | Time value to load: seconds, nanoseconds, fraction |
| period_ns_i | input | 32 | Whole nanoseconds added per cycle |
| period_frac_i | input | 16 | Fractional nanoseconds added per cycle |
| capture_i | input | 1 | Capture strobe for the three views |
| time_o | output | 96 | Live time of day |
| cap_v2_o | output | 96 | Captured 96-bit time |
| cap_v1_o | output | 64 | Captured 32-bit seconds and nanoseconds |
| cap_cf_o | output | 64 | Captured 48-bit total nanoseconds and fraction |

## Verification
Several properties are checked on every cycle by assertions. The nanosecond field always stays below one billion. The seconds step by at most one when no load occurs. A load takes effect, with the clamp applied. A capture records the earlier live time, and the captured views hold between strobes. The low half of the V1 view always matches the nanoseconds in the captured 96-bit view. The exact arithmetic can only be shown by the bench scenarios, which compare every cycle against an independent model. That arithmetic covers fraction carries, the billion rollover, wrapping of the 48-bit seconds, and the multiply-and-truncate of the correction field.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
  localparam int SEC_W    = 48;
  localparam int NS_W     = 32;
  localparam int FRAC_W   = 16;
  localparam int TOD_W    = SEC_W + NS_W + FRAC_W;
  localparam int V1_SEC_W = 32;
  localparam int V1_W     = V1_SEC_W + NS_W;
  localparam int CF_NS_W  = 48;
  localparam int CF_W     = CF_NS_W + FRAC_W;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_t;
endpackage

// File: rtl/ptp_tod_step.sv
`timescale 1ns/1ps
module ptp_tod_step
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  tod_t              cur_i,
  input  logic [NS_W-1:0]   period_ns_i,
  input  logic [FRAC_W-1:0] period_frac_i,
  output tod_t              nxt_o
);
  localparam logic [NS_W:0] WRAP_EXT = (NS_W+1)'(NS_WRAP);

  logic [FRAC_W:0] frac_sum;
  logic [NS_W:0]   ns_sum;
  logic            ns_wrap;

  always_comb begin
    frac_sum = {1'b0, cur_i.frac} + {1'b0, period_frac_i};
    ns_sum   = {1'b0, cur_i.ns} + {1'b0, period_ns_i} + {{NS_W{1'b0}}, frac_sum[FRAC_W]};
    ns_wrap  = (ns_sum >= WRAP_EXT);
    nxt_o.frac = frac_sum[FRAC_W-1:0];
    if (ns_wrap) begin
      ns_sum    = ns_sum - WRAP_EXT;
      nxt_o.sec = cur_i.sec + {{(SEC_W-1){1'b0}}, 1'b1};
    end else begin
      nxt_o.sec = cur_i.sec;
    end
    nxt_o.ns = ns_sum[NS_W-1:0];
  end
endmodule

// File: rtl/ptp_tod_load.sv
`timescale 1ns/1ps
module ptp_tod_load
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  tod_t raw_i,
  output tod_t clean_o
);
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_WRAP);
  localparam logic [NS_W-1:0] NS_MAX   = NS_W'(NS_WRAP - 1);

  always_comb begin
    clean_o = raw_i;
    if (raw_i.ns >= NS_LIMIT) clean_o.ns = NS_MAX;
  end
endmodule

// File: rtl/ptp_tod_encode.sv
`timescale 1ns/1ps
module ptp_tod_encode
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  tod_t            tod_i,
  output logic [V1_W-1:0] v1_o,
  output logic [CF_W-1:0] cf_o
);
  localparam logic [CF_NS_W-1:0] SCALE = CF_NS_W'(NS_WRAP);

  logic [CF_NS_W-1:0] sec_ext;
  logic [CF_NS_W-1:0] sec_ns;
  logic [CF_NS_W-1:0] total_ns;

  always_comb begin
    sec_ext  = CF_NS_W'(tod_i.sec);
    sec_ns   = sec_ext * SCALE;  // truncated modulo 2^CF_NS_W
    total_ns = sec_ns + CF_NS_W'(tod_i.ns);
    v1_o     = {tod_i.sec[V1_SEC_W-1:0], tod_i.ns};
    cf_o     = {total_ns, tod_i.frac};
  end
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TOD_W-1:0]  load_time_i,
  input  logic [NS_W-1:0]   period_ns_i,
  input  logic [FRAC_W-1:0] period_frac_i,
  input  logic              capture_i,
  output logic [TOD_W-1:0]  time_o,
  output logic [TOD_W-1:0]  cap_v2_o,
  output logic [V1_W-1:0]   cap_v1_o,
  output logic [CF_W-1:0]   cap_cf_o
);
  localparam logic [NS_W-1:0] NS_LIMIT = NS_W'(NS_WRAP);
  localparam logic [NS_W-1:0] NS_MAX   = NS_W'(NS_WRAP - 1);

  tod_t            tod_q, tod_step, tod_loaded, tod_d;
  logic [V1_W-1:0] v1_now;
  logic [CF_W-1:0] cf_now;

  ptp_tod_step #(.NS_WRAP(NS_WRAP)) i_step (
    .cur_i         (tod_q),
    .period_ns_i   (period_ns_i),
    .period_frac_i (period_frac_i),
    .nxt_o         (tod_step)
  );

  ptp_tod_load #(.NS_WRAP(NS_WRAP)) i_load (
    .raw_i   (tod_t'(load_time_i)),
    .clean_o (tod_loaded)
  );

  ptp_tod_encode #(.NS_WRAP(NS_WRAP)) i_encode (
    .tod_i (tod_q),
    .v1_o  (v1_now),
    .cf_o  (cf_now)
  );

  assign tod_d = load_i ? tod_loaded : tod_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tod_q <= '0;
    else         tod_q <= tod_d;
  end

  // all views sampled from the same pre-edge state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_v2_o <= '0;
      cap_v1_o <= '0;
      cap_cf_o <= '0;
    end else if (capture_i) begin
      cap_v2_o <= tod_q;
      cap_v1_o <= v1_now;
      cap_cf_o <= cf_now;
    end
  end

  assign time_o = tod_q;

  assert_period_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_ns_i < NS_LIMIT);

  assert_ns_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_o[NS_W+FRAC_W-1:FRAC_W] < NS_LIMIT);

  assert_sec_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (time_o[TOD_W-1:NS_W+FRAC_W] == $past(time_o[TOD_W-1:NS_W+FRAC_W])) ||
                (time_o[TOD_W-1:NS_W+FRAC_W] == $past(time_o[TOD_W-1:NS_W+FRAC_W]) + 1'b1));

  assert_load_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o[TOD_W-1:NS_W+FRAC_W] == $past(load_time_i[TOD_W-1:NS_W+FRAC_W])) &&
               (time_o[FRAC_W-1:0] == $past(load_time_i[FRAC_W-1:0])));

  assert_load_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_time_i[NS_W+FRAC_W-1:FRAC_W] >= NS_LIMIT) |=>
      time_o[NS_W+FRAC_W-1:FRAC_W] == NS_MAX);

  assert_capture_v2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> cap_v2_o == $past(time_o));

  assert_v1_ns_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v1_o[NS_W-1:0] == cap_v2_o[NS_W+FRAC_W-1:FRAC_W]);

  assert_cf_frac_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_cf_o[FRAC_W-1:0] == cap_v2_o[FRAC_W-1:0]);

  assert_capture_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(cap_v2_o) && $stable(cap_v1_o) && $stable(cap_cf_o));
endmodule

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;
  localparam logic [63:0] BILLION = 64'd1000000000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [95:0] load_time_i = '0;
  logic [31:0] period_ns_i = '0;
  logic [15:0] period_frac_i = '0;
  logic        capture_i = 1'b0;
  logic [95:0] time_o, cap_v2_o;
  logic [63:0] cap_v1_o, cap_cf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [95:0] m_time = '0;
  logic [95:0] m_cap = '0;

  always #2.5 clk_i = ~clk_i;

  ptp_tod_counter i_ptp_tod_counter (
    .clk_i, .rst_ni, .load_i, .load_time_i, .period_ns_i, .period_frac_i,
    .capture_i, .time_o, .cap_v2_o, .cap_v1_o, .cap_cf_o
  );

  function automatic logic [95:0] f_adv(logic [95:0] t, logic [31:0] pns, logic [15:0] pf);
    logic [47:0] s;
    logic [63:0] n;
    logic [31:0] f;
    s = t[95:48];
    f = {16'd0, t[15:0]} + {16'd0, pf};
    n = {32'd0, t[47:16]} + {32'd0, pns} + {63'd0, f[16]};
    if (n >= BILLION) begin
      n = n - BILLION;
      s = s + 48'd1;
    end
    return {s, n[31:0], f[15:0]};
  endfunction

  function automatic logic [95:0] f_clamp(logic [95:0] t);
    logic [95:0] r;
    r = t;
    if ({32'd0, t[47:16]} >= BILLION) r[47:16] = 32'd999999999;
    return r;
  endfunction

  function automatic logic [63:0] f_v1(logic [95:0] t);
    return {t[79:48], t[47:16]};
  endfunction

  function automatic logic [63:0] f_cf(logic [95:0] t);
    logic [63:0] p;
    p = {16'd0, t[95:48]} * BILLION + {32'd0, t[47:16]};
    return {p[47:0], t[15:0]};
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " time"}, time_o, m_time);
    chk({req, " v2"}, cap_v2_o, m_cap);
    chk({req, " v1 R7"}, {32'd0, cap_v1_o}, {32'd0, f_v1(m_cap)});
    chk({req, " cf R8"}, {32'd0, cap_cf_o}, {32'd0, f_cf(m_cap)});
  endtask

  task automatic cycle(input logic ld, input logic [95:0] lt, input logic cap,
                       input logic [31:0] pns, input logic [15:0] pf, input string req);
    @(negedge clk_i);
    load_i = ld; load_time_i = lt; capture_i = cap;
    period_ns_i = pns; period_frac_i = pf;
    @(posedge clk_i);
    if (cap) m_cap = m_time;
    m_time = ld ? f_clamp(lt) : f_adv(m_time, pns, pf);
    #1;
    check_all(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1588));
    repeat (3) @(posedge clk_i);
    #1;
    check_all("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 plain advance with fraction carry
    cycle(1'b1, {48'd5, 32'd100, 16'hFFF0}, 1'b0, 32'd8, 16'd0, "R4 load");
    cycle(1'b0, '0, 1'b0, 32'd8, 16'h0020, "R2 frac carry");
    cycle(1'b0, '0, 1'b1, 32'd8, 16'h8000, "R2 advance");
    // R3 billion rollover
    cycle(1'b1, {48'd7, 32'd999999999, 16'hFFFF}, 1'b0, 32'd0, 16'd0, "R4 load edge");
    cycle(1'b0, '0, 1'b0, 32'd0, 16'd1, "R3 rollover via frac");
    cycle(1'b0, '0, 1'b1, 32'd999999999, 16'd0, "R3 large period");
    // R10 seconds wrap
    cycle(1'b1, {48'hFFFF_FFFF_FFFF, 32'd999999990, 16'd0}, 1'b0, 32'd0, 16'd0, "R4 load max sec");
    cycle(1'b0, '0, 1'b1, 32'd10, 16'd0, "R10 sec wrap");
    // R5 clamp
    cycle(1'b1, {48'd3, 32'hFFFF_FFFF, 16'h1234}, 1'b0, 32'd8, 16'd0, "R5 clamp max");
    cycle(1'b1, {48'd3, 32'd1000000000, 16'h0001}, 1'b0, 32'd8, 16'd0, "R5 clamp billion");
    // R6 capture with load same cycle captures pre-load time
    cycle(1'b1, {48'd0, 32'd42, 16'd0}, 1'b1, 32'd8, 16'd0, "R6 capture with load");
    // R9 hold across several cycles
    for (int i = 0; i < 4; i++) cycle(1'b0, '0, 1'b0, 32'd333333333, 16'h5555, "R9 hold");
    // R8 large seconds for truncation
    cycle(1'b1, {48'h1234_5678_9ABC, 32'd123456789, 16'hBEEF}, 1'b0, 32'd0, 16'd0, "R4 load big");
    cycle(1'b0, '0, 1'b1, 32'd0, 16'd0, "R8 cf truncation");
    cycle(1'b0, '0, 1'b0, 32'd0, 16'd0, "R8 zero period");

    for (int i = 0; i < 600; i++) begin
      logic        ld, cap;
      logic [95:0] lt;
      logic [31:0] pns;
      logic [15:0] pf;
      ld  = ($urandom_range(15, 0) == 0);
      cap = ($urandom_range(3, 0) == 0);
      lt  = {$urandom(), $urandom(), $urandom()};
      if ($urandom_range(1, 0) == 1) lt[47:16] = 32'd999999000 + 32'($urandom_range(2000, 0));
      case ($urandom_range(2, 0))
        0: pns = 32'd8;
        1: pns = 32'($urandom_range(999, 0));
        default: pns = 32'($urandom_range(999999999, 0));
      endcase
      pf = 16'($urandom());
      cycle(ld, lt, cap, pns, pf, "R2 R3 R6 random");
    end
    finish_run();
  end
endmodule